// File: doc/BRIEF.md
# Overpressure Threshold Trim Potentiometer Controller

This block sets a 100-position non-volatile digital potentiometer whose wiper fixes an overpressure trip threshold. A host issues one of three commands: move the wiper up by N steps, move it down by N steps, or store the current wiper position. The block turns each command into timed waveforms on three active-low control lines to the device: chip select, increment and up/down direction. It reports busy until the waveform is complete.

A hardware interlock jumper sits in series with chip select. With the jumper absent, chip select never reaches the device, so neither stepping nor storing has any effect. The block also contains a cycle-level model of the device, which tracks the wiper position and the stored position. A power-cycle pulse reloads the wiper from the stored position, as the device does at power-on. Converting the wiper position into an analog gain is not part of this block.

Top module: `trim_pot_ctrl`

## Requirements
- R1: After reset, chip select is high, increment is high, direction is low, busy is low, and the wiper and the stored position both equal INIT_POS (50).
- R2: A command with op 2'b01 (up) and a count N greater than 0 holds direction high while chip select is low. It drives N falling edges of increment, and each edge raises the wiper by one position.
- R3: A command with op 2'b10 (down) and a count N greater than 0 holds direction low. Each of its N increment falling edges lowers the wiper by one position.
- R4: The wiper saturates at position 0 and at position STEPS-1 (99). It never wraps.
- R5: When the jumper input is low, the chip select pin stays high. Wiper and stored position then stay unchanged under any command, although the command still runs its full timing.
- R6: Op 2'b11 (store) lowers chip select with increment high and then raises it with increment still high. This copies the wiper into the stored position.
- R7: A step command finishes by raising chip select while increment is still low, so the stored position is not changed.
- R8: Busy stays high for 2*SETUP_CYC+(2N+1)*PULSE_CYC cycles for a step command and 2*SETUP_CYC+PULSE_CYC cycles for a store. Every increment low pulse lasts at least PULSE_CYC cycles, and direction is stable while chip select is low.
- R9: The block ignores a command while busy, a command with op 2'b00, and an up or down command with count 0. In each case busy stays low, or the running command is unaffected.
- R10: A one-cycle power-cycle pulse sets the wiper to the stored position at the next clock edge. If it falls in the same cycle as an increment edge, the reload wins and that step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, sampled when not busy |
| cmd_op_i | input | 2 | 01 up, 10 down, 11 store, 00 none |
| cmd_count_i | input | $clog2(STEPS) | Number of steps for up/down |
| jumper_i | input | 1 | Interlock jumper fitted (high) |
| power_cycle_i | input | 1 | Pulse: device power-on, recall stored position |
| busy_o | output | 1 | Command in progress |
| pot_cs_no | output | 1 | Chip select to device, active low, gated by jumper |
| pot_inc_no | output | 1 | Increment strobe, active low |
| pot_dir_o | output | 1 | Direction, high = up |
| wiper_o | output | $clog2(STEPS) | Current wiper position |

## Verification
Two functions can land in the same cycle: the power-on recall and a wiper step caused by an increment falling edge. The bench counts cycles from command acceptance and places a one-cycle power-cycle pulse exactly on the edge where the first step of a three-step up command takes effect. The result is judged by the final wiper: the stored position plus two means the recall won and the coincident step was dropped. The stored position plus three, or the old wiper plus three, exposes a wrong priority. Store-versus-step release is judged separately by recalling after a plain step command.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_UP    = 2'b01,
    OP_DOWN  = 2'b10,
    OP_STORE = 2'b11
  } trim_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR,
    S_SEL,
    S_DN,
    S_UP,
    S_REL,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/trim_seq.sv
module trim_seq
  import trim_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int PULSE_CYC = 2,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [CNT_W-1:0] cmd_count_i,
  output logic             busy_o,
  output logic             cs_no,
  output logic             inc_no,
  output logic             dir_o
);
  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int TMR_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [TMR_W-1:0] SETUP_LD = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);

  seq_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] remain_q;
  logic             store_q;
  logic             accept;
  trim_op_e         op;

  assign op     = trim_op_e'(cmd_op_i);
  assign accept = cmd_valid_i && (state_q == S_IDLE) &&
                  ((op == OP_STORE) ||
                   (((op == OP_UP) || (op == OP_DOWN)) && (cmd_count_i != '0)));
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      tmr_q    <= '0;
      remain_q <= '0;
      store_q  <= 1'b0;
      cs_no    <= 1'b1;
      inc_no   <= 1'b1;
      dir_o    <= 1'b0;
    end else if (state_q == S_IDLE) begin
      if (accept) begin
        state_q  <= S_DIR;
        tmr_q    <= SETUP_LD;
        remain_q <= cmd_count_i;
        store_q  <= (op == OP_STORE);
        dir_o    <= (op == OP_UP);
      end
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end else begin
      unique case (state_q)
        S_DIR: begin
          cs_no   <= 1'b0;
          state_q <= S_SEL;
          tmr_q   <= SETUP_LD;
        end
        S_SEL: begin
          tmr_q <= PULSE_LD;
          if (store_q) begin
            cs_no   <= 1'b1;        // release with inc high: commit
            state_q <= S_HOLD;
          end else begin
            inc_no  <= 1'b0;
            state_q <= S_DN;
          end
        end
        S_DN: begin
          tmr_q    <= PULSE_LD;
          remain_q <= remain_q - 1'b1;
          if (remain_q == CNT_W'(1)) begin
            cs_no   <= 1'b1;        // release with inc low: no commit
            state_q <= S_REL;
          end else begin
            inc_no  <= 1'b1;
            state_q <= S_UP;
          end
        end
        S_UP: begin
          inc_no  <= 1'b0;
          tmr_q   <= PULSE_LD;
          state_q <= S_DN;
        end
        S_REL: begin
          inc_no  <= 1'b1;
          tmr_q   <= PULSE_LD;
          state_q <= S_HOLD;
        end
        S_HOLD: begin
          dir_o   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_interlock.sv
module trim_interlock (
  input  logic jumper_i,
  input  logic cs_ni,
  output logic cs_no
);
  // open jumper leaves the device select line pulled inactive
  assign cs_no = cs_ni | ~jumper_i;
endmodule

// File: rtl/trim_wiper_model.sv
module trim_wiper_model #(
  parameter int STEPS    = 100,
  parameter int INIT_POS = 50,
  parameter int POS_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             inc_ni,
  input  logic             dir_i,
  input  logic             power_cycle_i,
  output logic [POS_W-1:0] wiper_o
);
  localparam logic [POS_W-1:0] TOP_POS  = POS_W'(STEPS - 1);
  localparam logic [POS_W-1:0] INIT_VAL = POS_W'(INIT_POS);

  logic             cs_prev_q;
  logic             inc_prev_q;
  logic [POS_W-1:0] stored_q;
  logic             step_ev;
  logic             store_ev;

  assign step_ev  = inc_prev_q && !inc_ni && !cs_ni;
  assign store_ev = !cs_prev_q && cs_ni && inc_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q  <= 1'b1;
      inc_prev_q <= 1'b1;
      stored_q   <= INIT_VAL;
      wiper_o    <= INIT_VAL;
    end else begin
      cs_prev_q  <= cs_ni;
      inc_prev_q <= inc_ni;
      if (store_ev) stored_q <= wiper_o;
      if (power_cycle_i) begin
        wiper_o <= stored_q;
      end else if (step_ev) begin
        if (dir_i && (wiper_o != TOP_POS))  wiper_o <= wiper_o + 1'b1;
        if (!dir_i && (wiper_o != '0))      wiper_o <= wiper_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trim_pot_ctrl.sv
module trim_pot_ctrl #(
  parameter int STEPS     = 100,
  parameter int INIT_POS  = 50,
  parameter int SETUP_CYC = 3,
  parameter int PULSE_CYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [1:0]               cmd_op_i,
  input  logic [$clog2(STEPS)-1:0] cmd_count_i,
  input  logic                     jumper_i,
  input  logic                     power_cycle_i,
  output logic                     busy_o,
  output logic                     pot_cs_no,
  output logic                     pot_inc_no,
  output logic                     pot_dir_o,
  output logic [$clog2(STEPS)-1:0] wiper_o
);
  localparam int POS_W = $clog2(STEPS);

  logic seq_cs_n;

  trim_seq #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .CNT_W    (POS_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_count_i(cmd_count_i),
    .busy_o     (busy_o),
    .cs_no      (seq_cs_n),
    .inc_no     (pot_inc_no),
    .dir_o      (pot_dir_o)
  );

  trim_interlock i_lock (
    .jumper_i(jumper_i),
    .cs_ni   (seq_cs_n),
    .cs_no   (pot_cs_no)
  );

  trim_wiper_model #(
    .STEPS   (STEPS),
    .INIT_POS(INIT_POS),
    .POS_W   (POS_W)
  ) i_model (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (pot_cs_no),
    .inc_ni       (pot_inc_no),
    .dir_i        (pot_dir_o),
    .power_cycle_i(power_cycle_i),
    .wiper_o      (wiper_o)
  );
endmodule

// File: rtl/trim_pot_chk.sv
module trim_pot_chk #(
  parameter int STEPS     = 100,
  parameter int PULSE_CYC = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmd_valid_i,
  input logic [1:0]               cmd_op_i,
  input logic [$clog2(STEPS)-1:0] cmd_count_i,
  input logic                     jumper_i,
  input logic                     power_cycle_i,
  input logic                     busy_o,
  input logic                     pot_cs_no,
  input logic                     pot_inc_no,
  input logic                     pot_dir_o,
  input logic [$clog2(STEPS)-1:0] wiper_o
);
  localparam int LW = $clog2(PULSE_CYC + 2) + 1;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  logic [LW-1:0] low_cnt_q;
  logic          takes_cmd;

  assign takes_cmd = cmd_valid_i && !busy_o &&
                     ((cmd_op_i == 2'b11) ||
                      ((cmd_op_i != 2'b00) && (cmd_count_i != '0)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           low_cnt_q <= '0;
    else if (pot_inc_no)                   low_cnt_q <= '0;
    else if (low_cnt_q != LMAX)            low_cnt_q <= low_cnt_q + 1'b1;
  end

  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (pot_cs_no && pot_inc_no && !pot_dir_o));

  a_r4_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wiper_o <= ($clog2(STEPS))'(STEPS - 1));

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_cycle_i |=> ((wiper_o == $past(wiper_o)) ||
                        (wiper_o == $past(wiper_o) + 1'b1) ||
                        (wiper_o == $past(wiper_o) - 1'b1)));

  a_r5_interlock_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jumper_i && !power_cycle_i) |=> $stable(wiper_o));

  a_r8_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pot_inc_no) |-> (low_cnt_q >= LW'(PULSE_CYC)));

  a_r8_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pot_cs_no && $past(!pot_cs_no)) |-> $stable(pot_dir_o));

  a_r6_select_with_inc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pot_cs_no) |-> pot_inc_no);

  a_r9_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takes_cmd |=> busy_o);

  a_r9_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !takes_cmd) |=> !busy_o);
endmodule

bind trim_pot_ctrl trim_pot_chk #(
  .STEPS    (STEPS),
  .PULSE_CYC(PULSE_CYC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_count_i  (cmd_count_i),
  .jumper_i     (jumper_i),
  .power_cycle_i(power_cycle_i),
  .busy_o       (busy_o),
  .pot_cs_no    (pot_cs_no),
  .pot_inc_no   (pot_inc_no),
  .pot_dir_o    (pot_dir_o),
  .wiper_o      (wiper_o)
);

// File: tb/test_trim_pot_ctrl.sv
`timescale 1ns/1ps
module test_trim_pot_ctrl;
  localparam int STEPS = 100;
  localparam int INIT  = 50;
  localparam int SU    = 3;
  localparam int PW    = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [6:0] cnt = '0;
  logic       jumper = 1'b1;
  logic       pwr = 1'b0;
  logic       busy, cs_n, inc_n, dir;
  logic [6:0] wiper;

  always #2 clk = ~clk;

  trim_pot_ctrl #(.STEPS(STEPS), .INIT_POS(INIT), .SETUP_CYC(SU), .PULSE_CYC(PW)) i_trim_pot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_count_i(cnt), .jumper_i(jumper), .power_cycle_i(pwr),
    .busy_o(busy), .pot_cs_no(cs_n), .pot_inc_no(inc_n), .pot_dir_o(dir),
    .wiper_o(wiper));

  int n_cmp = 0, n_bad = 0;
  int exp_w = INIT, exp_st = INIT;
  int q_w[$], q_len[$];
  string q_tag[$];
  int busy_cnt = 0, blocked_low = 0;
  logic busy_prev = 1'b0;
  int m_w, m_l;
  string m_t;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scores each command at its completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      else if (busy_prev) begin
        if (q_w.size() == 0) check(1'b0, "R9 unexpected completion", 0, 1);
        else begin
          m_w = q_w.pop_front(); m_l = q_len.pop_front(); m_t = q_tag.pop_front();
          check(int'(wiper) == m_w, {m_t, " wiper"}, int'(wiper), m_w);
          check(busy_cnt == m_l, "R8 busy length", busy_cnt, m_l);
        end
        busy_cnt = 0;
      end
      busy_prev = busy;
      if (!jumper && !cs_n) blocked_low++;
    end
  end

  function automatic int model_step(input int w, input int o, input int n);
    int r = w;
    if (o == 1) r = (w + n > STEPS - 1) ? STEPS - 1 : w + n;
    if (o == 2) r = (w - n < 0) ? 0 : w - n;
    return r;
  endfunction

  task automatic expect_cmd(input int o, input int n, input string tag);
    if (jumper) begin
      if (o == 3) exp_st = exp_w;
      else        exp_w  = model_step(exp_w, o, n);
    end
    q_w.push_back(exp_w);
    q_len.push_back((o == 3) ? 2*SU + PW : 2*SU + (2*n + 1)*PW);
    q_tag.push_back(tag);
  endtask

  task automatic issue(input int o, input int n, input string tag, input bit intrude);
    expect_cmd(o, n, tag);
    @(negedge clk); valid = 1'b1; op = 2'(o); cnt = 7'(n);
    @(negedge clk);
    if (intrude) begin
      op = 2'b10; cnt = 7'd5;   // arrives while busy
      @(negedge clk);
    end
    valid = 1'b0;
    wait (q_w.size() == 0);
    @(negedge clk);
  endtask

  task automatic recall(input string tag);
    exp_w = exp_st;
    @(negedge clk); pwr = 1'b1;
    @(negedge clk); pwr = 1'b0;
    check(int'(wiper) == exp_w, tag, int'(wiper), exp_w);
  endtask

  task automatic ignored(input int o, input int n, input string tag);
    @(negedge clk); valid = 1'b1; op = 2'(o); cnt = 7'(n);
    @(negedge clk); valid = 1'b0;
    check(busy == 1'b0, tag, int'(busy), 0);
    repeat (2) @(negedge clk);
    check(int'(wiper) == exp_w, tag, int'(wiper), exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1 && inc_n == 1'b1, "R1 idle select/inc", {30'd0, cs_n, inc_n}, 3);
    check(dir == 1'b0 && busy == 1'b0, "R1 idle dir/busy", {30'd0, dir, busy}, 0);
    check(int'(wiper) == INIT, "R1 reset wiper", int'(wiper), INIT);

    issue(1, 5, "R2 up 5", 1'b0);
    issue(2, 8, "R3 down 8", 1'b0);
    issue(3, 0, "R6 store", 1'b0);
    issue(1, 3, "R2 up 3", 1'b0);
    recall("R6 recall after store");
    issue(1, 2, "R7 up 2", 1'b0);
    recall("R7 step did not store");
    issue(1, 60, "R4 saturate top", 1'b0);
    issue(2, 120, "R4 saturate bottom", 1'b0);

    jumper = 1'b0;
    issue(1, 10, "R5 blocked up", 1'b0);
    issue(3, 0, "R5 blocked store", 1'b0);
    check(blocked_low == 0, "R5 select held high", blocked_low, 0);
    recall("R5 stored unchanged");
    jumper = 1'b1;

    ignored(0, 4, "R9 op none");
    ignored(1, 0, "R9 up count 0");
    ignored(2, 0, "R9 down count 0");
    issue(1, 2, "R9 command while busy", 1'b1);

    // R10: recall on the same edge as the first step of up 3
    exp_w = model_step(exp_st, 1, 2);
    q_w.push_back(exp_w); q_len.push_back(2*SU + 7*PW); q_tag.push_back("R10 recall wins");
    @(negedge clk); valid = 1'b1; op = 2'b01; cnt = 7'd3;
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
    repeat (2*SU) @(negedge clk);
    pwr = 1'b1;
    @(negedge clk); pwr = 1'b0;
    wait (q_w.size() == 0);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule